// File: doc/BRIEF.md
# Push-Button Pseudo-Random Two-Digit Generator

This block produces a pseudo-random number from 1 to 15 each time a generate button is pressed and presents it as two decimal digits for a pair of seven-segment displays. Inside is a four-bit linear-feedback shift register. It shifts toward bit 0, and the exclusive-OR of bit 0 and bit 3 enters at bit 3. This gives the maximal sequence of 15 nonzero states.

The generate input must already be debounced. An internal rising-edge detector makes one press produce exactly one step, however long the button is held. A synchronous reset loads the all-ones seed into the register and blanks the display to 00. The display stays at 00 until the first press after reset. From then on it shows the register contents in BCD, and the outputs are registered.

Top module: `prng_dice_display`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with all ones (value 15), and both digit outputs read 0 after that edge.
- R2: At a clock edge where `gen_btn` is high and was low at the previous edge, the register takes the value {Q[0]^Q[3], Q[3:1]}. The new value then appears as BCD, with the tens on `digit_tens` and the ones on `digit_ones`, after that same edge.
- R3: While `gen_btn` stays high, or stays low, the register and the digits do not change.
- R4: After reset the digits read 00 until the first rising edge of `gen_btn`. The first press shows 7, which is the successor of the seed.
- R5: Starting from the seed, successive presses visit every value from 1 to 15 exactly once and return to 15 after 15 presses. The value 0 never occurs.
- R6: Reset takes priority over a press in the same cycle. A button held high through the end of reset does not count as a press.
- R7: `digit_tens` is always 0 or 1, and `digit_ones` is always at most 9.
- R8: A press that lasts one cycle and follows a one-cycle release counts as a separate step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_btn | input | 1 | Debounced generate button, active high |
| digit_tens | output | 4 | BCD tens digit of the shown value |
| digit_ones | output | 4 | BCD ones digit of the shown value |

## Verification
Reset and a new button press can occur in the same cycle. Reset must win, and the edge history must still follow the button, so that a button held through reset does not produce a step once reset drops. The bench raises `gen_btn` at the same edge where `rst` is high and keeps it high afterwards. It expects 00 for as long as the button is held. It then releases the button and presses again, and expects exactly one step from the seed, which shows 07.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int DIGIT_W = 4;

  // Binary to BCD by shift-and-add-3, producing NDIG packed digits.
  function automatic logic [15:0] bin_to_bcd16(input logic [15:0] bin, input int nbits);
    logic [15:0] acc;
    acc = '0;
    for (int i = 15; i >= 0; i--) begin
      if (i < nbits) begin
        for (int d = 0; d < 4; d++) begin
          if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
        end
        acc = {acc[14:0], bin[i]};
      end
    end
    return acc;
  endfunction
endpackage

// File: rtl/prng_rise_detect.sv
module prng_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise_pulse
);
  logic level_q;

  // History tracks the input even in reset, so a held button is not a press.
  always_ff @(posedge clk) begin
    level_q <= level_in;
  end

  assign rise_pulse = level_in & ~level_q & ~rst;

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/prng_lfsr.sv
module prng_lfsr #(
  parameter int WIDTH  = 4,
  parameter int TAP_LO = 0,
  parameter int TAP_HI = 3,
  parameter logic [WIDTH-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] state_next
);
  logic fb;

  assign fb         = state[TAP_LO] ^ state[TAP_HI];
  assign state_next = {fb, state[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= state_next;
  end

  assert_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));
endmodule

// File: rtl/prng_bcd_digits.sv
module prng_bcd_digits #(
  parameter int BIN_W = 4,
  parameter int NDIG  = 2
) (
  input  logic [BIN_W-1:0]                    bin,
  output logic [NDIG*prng_pkg::DIGIT_W-1:0]   bcd
);
  import prng_pkg::*;
  logic [15:0] wide;

  always_comb begin
    wide = bin_to_bcd16(16'(bin), BIN_W);
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign bcd[g*DIGIT_W +: DIGIT_W] = wide[g*4 +: 4];
  end
endmodule

// File: rtl/prng_dice_display.sv
module prng_dice_display #(
  parameter int WIDTH = 4,
  parameter int NDIG  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gen_btn,
  output logic [3:0] digit_tens,
  output logic [3:0] digit_ones
);
  import prng_pkg::*;
  localparam int BCD_W = NDIG * DIGIT_W;

  logic             press;
  logic [WIDTH-1:0] lfsr_q, lfsr_d;
  logic [BCD_W-1:0] bcd_next;
  logic [BCD_W-1:0] shown_q;
  logic             armed_q;

  prng_rise_detect u_edge (
    .clk(clk), .rst(rst), .level_in(gen_btn), .rise_pulse(press)
  );

  prng_lfsr #(.WIDTH(WIDTH), .TAP_LO(0), .TAP_HI(3), .SEED('1)) u_lfsr (
    .clk(clk), .rst(rst), .step(press), .state(lfsr_q), .state_next(lfsr_d)
  );

  prng_bcd_digits #(.BIN_W(WIDTH), .NDIG(NDIG)) u_bcd (
    .bin(lfsr_d), .bcd(bcd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q <= '0;
      armed_q <= 1'b0;
    end else if (press) begin
      shown_q <= bcd_next;
      armed_q <= 1'b1;
    end
  end

  assign digit_ones = shown_q[0 +: 4];
  assign digit_tens = shown_q[4 +: 4];

  assert_bcd_range_R7: assert property (@(posedge clk) disable iff (rst)
    digit_tens <= 4'd1 && digit_ones <= 4'd9);
  assert_blank_until_press_R4: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> (digit_tens == 4'd0 && digit_ones == 4'd0));
  assert_press_changes_R2: assert property (@(posedge clk) disable iff (rst)
    press |=> (digit_tens != 4'd0 || digit_ones != 4'd0));
endmodule

// File: tb/prng_dice_display_bench.sv
module prng_dice_display_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gen_btn = 1'b0;
  logic [3:0] digit_tens, digit_ones;
  int checks = 0;
  int fails = 0;
  logic [3:0] model;

  always #5 clk = ~clk;

  prng_dice_display u_prng_dice_display (
    .clk(clk), .rst(rst), .gen_btn(gen_btn),
    .digit_tens(digit_tens), .digit_ones(digit_ones)
  );

  function automatic logic [3:0] succ(input logic [3:0] v);
    return {v[0] ^ v[3], v[3:1]};
  endfunction

  task automatic expect_val(input int val, input string req);
    int got;
    got = digit_tens * 10 + digit_ones;
    checks++;
    if (digit_tens > 1 || digit_ones > 9 || got != val) begin
      fails++;
      $display("FAIL %s: got %0d%0d expected %0d", req, digit_tens, digit_ones, val);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; gen_btn = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model = 4'hF;
  endtask

  task automatic press_once();
    @(negedge clk); gen_btn = 1'b1;
    @(negedge clk); gen_btn = 1'b0;
    model = succ(model);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_val(0, "R1");
    repeat (5) @(negedge clk);
    expect_val(0, "R4");
    press_once();
    expect_val(7, "R4");
  endtask

  task automatic t_full_cycle();
    bit seen [16];
    do_reset();
    for (int i = 0; i < 16; i++) seen[i] = 1'b0;
    for (int i = 0; i < 15; i++) begin
      press_once();
      expect_val(int'(model), "R2");
      checks++;
      if (model == 0 || seen[model]) begin
        fails++;
        $display("FAIL R5: value %0d repeated or zero, expected fresh nonzero", model);
      end
      seen[model] = 1'b1;
    end
    expect_val(15, "R5");
  endtask

  task automatic t_held();
    do_reset();
    @(negedge clk); gen_btn = 1'b1;
    model = succ(model);
    @(negedge clk); expect_val(int'(model), "R2");
    repeat (6) @(negedge clk);
    expect_val(int'(model), "R3");
    gen_btn = 1'b0;
    repeat (6) @(negedge clk);
    expect_val(int'(model), "R3");
  endtask

  task automatic t_collision();
    do_reset();
    press_once(); press_once();
    @(negedge clk); rst = 1'b1; gen_btn = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = 4'hF;
    expect_val(0, "R6");
    repeat (3) @(negedge clk);
    expect_val(0, "R6");
    gen_btn = 1'b0;
    @(negedge clk);
    press_once();
    expect_val(7, "R6");
  endtask

  task automatic t_fast_toggle();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); gen_btn = 1'b1;
      model = succ(model);
      @(negedge clk); gen_btn = 1'b0;
      expect_val(int'(model), "R8");
    end
  endtask

  initial begin
    t_reset_state();
    t_full_cycle();
    t_held();
    t_collision();
    t_fast_toggle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule